// File: doc/BRIEF.md
# Cell Payload Pattern Generator

This block fills the 48-byte payload field of outgoing ATM test cells. A one-cycle start strobe begins a cell. From the next cycle the block offers one payload byte per cycle on a valid/ready stream. The 48th byte carries a last flag. While the sink holds ready low, the offered byte does not change. The configuration inputs are captured when the cell starts, so the source of a cell cannot change partway through it.

Five payload sources are available:
- the departure time of the cell, taken from a free-running counter of 100 ns ticks;
- a PRBS-9, PRBS-15 or PRBS-23 stream that runs on from cell to cell;
- a PRBS-9 stream that restarts in every cell;
- one of three fixed byte patterns;
- a ramp of incrementing bytes.

With AAL-1 enabled, the first byte of the cell becomes a sequence header built from a CSI bit and a modulo-8 cell counter. The header is protected by a CRC and a parity bit. The chosen pattern then fills the other 47 bytes.

Top module: `pyld_pattern_gen`

## Requirements
- R1: After reset, `pay_valid` and `pay_last` are 0, the tick counter is 0, the AAL-1 cell counter is 0, and every PRBS register holds all ones.
- R2: A `cell_start` pulse while idle makes `pay_valid` rise on the next cycle. Exactly 48 bytes are then transferred. `pay_last` is 1 only on the 48th, and `pay_valid` is 0 in the cycle after the 48th transfer. A `cell_start` pulse while a cell is in progress is ignored.
- R3: While `pay_valid` is 1 and `pay_ready` is 0, `pay_data`, `pay_valid` and `pay_last` hold their values into the next cycle.
- R4: Source 0 (timestamp) sends the tick count as four bytes, most significant byte first, followed by 0x00 bytes. The count is the number of clock edges with `tick_100ns` high before the edge that accepted `cell_start`, and one sample supplies all four bytes.
- R5: Source 1 (continuous PRBS) selects the polynomial with `prbs_sel`: 0 gives x^9+x^5+1, 1 gives x^15+x^14+1, and 2 gives x^23+x^18+1. The value 3 is treated as 2. Each register is a Fibonacci shifter whose output bit is its top bit, and each byte is eight successive output bits with the first bit in bit 7. Each polynomial has its own register, and a register advances only for bytes that it supplies, so its sequence continues across cells.
- R6: In source 1 with `prbs_sel`=1 and `prbs15_inv`=1, every PRBS-15 byte is inverted. For other polynomials the invert input has no effect.
- R7: Source 2 (per-cell PRBS) produces PRBS-9 from an all-ones seed that is reloaded at every cell start. It does not disturb the continuous registers.
- R8: Source 3 (fixed) uses `fixed_sel`: 0 and 3 repeat `user_byte`, 1 alternates 0xAA,0x55 and 2 alternates 0xFF,0x00. Each alternating pattern starts with its first value on the first pattern byte.
- R9: Source 4 (ramp) starts at `user_byte` on the first pattern byte and adds one for each later byte, wrapping modulo 256.
- R10: With `aal1_en`, byte 0 is the header {CSI[7], count[6:4], CRC-3 over bits 7:4 with x^3+x+1 in [3:1], even parity over bits 7:1 in [0]}, where count is the number of AAL-1 cells sent before this one, modulo 8. The pattern then starts at byte 1, and the header byte does not advance any PRBS register.
- R11: Configuration inputs that change after the start of a cell have no effect on the bytes of that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_100ns | input | 1 | Advances the timestamp counter when high at a clock edge |
| cell_start | input | 1 | Starts a new cell payload when the block is idle |
| src_mode | input | 3 | Payload source: 0 timestamp, 1 continuous PRBS, 2 per-cell PRBS-9, 3 fixed, 4 ramp |
| prbs_sel | input | 2 | Polynomial for continuous PRBS: 0 PRBS-9, 1 PRBS-15, 2 or 3 PRBS-23 |
| prbs15_inv | input | 1 | Inverts PRBS-15 bytes |
| fixed_sel | input | 2 | Fixed pattern: 0/3 user byte, 1 AA/55, 2 FF/00 |
| user_byte | input | 8 | User constant, or start value of the ramp |
| aal1_en | input | 1 | Replaces byte 0 with the AAL-1 sequence header |
| aal1_csi | input | 1 | CSI bit of the header |
| pay_data | output | 8 | Payload byte |
| pay_valid | output | 1 | `pay_data` is valid |
| pay_last | output | 1 | Marks the 48th byte |
| pay_ready | input | 1 | The sink accepts the byte |

## Verification
Each source is exercised with several inputs, and each input is chosen to expose a different kind of mistake:
- Two PRBS-9 cells in a row show whether the continuous register really carries its state across cells.
- Two per-cell PRBS cells show whether the seed is reloaded at every cell start.
- PRBS-15 with and without inversion, and a PRBS-23 cell, expose wrong taps and wrong bit order.
- A ramp that starts at 0xF0 shows whether it wraps at 256.
- Nine AAL-1 cells take the header count through its wrap, and the expected CRC is found by long division, not by a shift register.
- Random cells change the configuration and pulse `cell_start` partway through, and they stall with random ready patterns, to show that each cell is frozen at its start and that the output holds while stalled.

// File: rtl/pyld_pkg.sv
package pyld_pkg;

  typedef enum logic [2:0] {
    SRC_TSTAMP = 3'd0,
    SRC_XPRBS  = 3'd1,
    SRC_CPRBS  = 3'd2,
    SRC_FIXED  = 3'd3,
    SRC_RAMP   = 3'd4
  } src_e;

  // Polynomial table: width and second tap for continuous PRBS slots
  function automatic int prbs_width(input int slot);
    return (slot == 0) ? 9 : (slot == 1) ? 15 : 23;
  endfunction

  function automatic int prbs_tap(input int slot);
    return (slot == 0) ? 5 : (slot == 1) ? 14 : 18;
  endfunction

  // AAL-1 header: CSI, 3-bit count, CRC-3 (x^3+x+1), even parity
  function automatic logic [7:0] aal1_hdr(input logic csi, input logic [2:0] cnt);
    logic [3:0] msg;
    logic [2:0] crc;
    logic       fb;
    logic [6:0] upper;
    msg = {csi, cnt};
    crc = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      fb  = msg[i] ^ crc[2];
      crc = {crc[1], crc[0] ^ fb, fb};
    end
    upper = {msg, crc};
    return {upper, ^upper};
  endfunction

  function automatic logic [7:0] fixed_byte(input logic [1:0] sel, input logic [7:0] ub,
                                            input logic odd);
    case (sel)
      2'd1:    return odd ? 8'h55 : 8'hAA;
      2'd2:    return odd ? 8'h00 : 8'hFF;
      default: return ub;
    endcase
  endfunction

endpackage

// File: rtl/pyld_lfsr.sv
module pyld_lfsr #(
  parameter int WIDTH = 9,
  parameter int TAP   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reseed,
  input  logic       advance,
  output logic [7:0] byte_o
);
  logic [WIDTH-1:0] st, nxt;

  always_comb begin
    nxt    = st;
    byte_o = '0;
    for (int i = 0; i < 8; i++) begin
      byte_o[7-i] = nxt[WIDTH-1];
      nxt = {nxt[WIDTH-2:0], nxt[WIDTH-1] ^ nxt[TAP-1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st <= '1;
    else if (reseed)  st <= '1;
    else if (advance) st <= nxt;
  end

  assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (!rst_n) st != '0);
  assert_lfsr_reseed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> st == '1);
  assert_lfsr_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reseed && !advance) |=> $stable(st));
endmodule

// File: rtl/pyld_tstamp.sv
module pyld_tstamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            capture,
  output logic [TS_W-1:0] ts_q
);
  logic [TS_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ts_q <= '0;
    end else begin
      if (tick)    cnt  <= cnt + 1'b1;
      if (capture) ts_q <= cnt;
    end
  end

  assert_ts_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  assert_ts_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(ts_q));
endmodule

// File: rtl/pyld_pattern_gen.sv
module pyld_pattern_gen
  import pyld_pkg::*;
#(
  parameter int CELL_BYTES = 48,
  parameter int TS_W       = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_100ns,
  input  logic       cell_start,
  input  logic [2:0] src_mode,
  input  logic [1:0] prbs_sel,
  input  logic       prbs15_inv,
  input  logic [1:0] fixed_sel,
  input  logic [7:0] user_byte,
  input  logic       aal1_en,
  input  logic       aal1_csi,
  output logic [7:0] pay_data,
  output logic       pay_valid,
  output logic       pay_last,
  input  logic       pay_ready
);
  localparam int IDX_W   = $clog2(CELL_BYTES);
  localparam int N_XPRBS = 3;
  localparam int TS_BYTES = TS_W / 8;

  // configuration frozen at cell start
  logic             active;
  logic [IDX_W-1:0] idx;
  src_e             mode_q;
  logic [1:0]       psel_q;
  logic             pinv_q, aal_q, csi_q;
  logic [1:0]       fsel_q;
  logic [7:0]       ubyte_q;
  logic [2:0]       seq_q, seq_ctr;
  logic [TS_W-1:0]  ts_q;

  // named events
  logic             start_ev, xfer_ev, done_ev, hdr_slot, last_slot;
  logic [IDX_W-1:0] pidx;
  logic [1:0]       psel_eff;
  logic [7:0]       xbyte [N_XPRBS];
  logic [7:0]       cbyte;

  assign start_ev  = cell_start && !active;
  assign xfer_ev   = active && pay_ready;
  assign last_slot = (idx == IDX_W'(CELL_BYTES - 1));
  assign done_ev   = xfer_ev && last_slot;
  assign hdr_slot  = aal_q && (idx == '0);
  assign pidx      = idx - IDX_W'(aal_q);
  assign psel_eff  = (psel_q == 2'd3) ? 2'd2 : psel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      mode_q  <= SRC_TSTAMP;
      psel_q  <= '0;
      pinv_q  <= 1'b0;
      fsel_q  <= '0;
      ubyte_q <= '0;
      aal_q   <= 1'b0;
      csi_q   <= 1'b0;
      seq_q   <= '0;
      seq_ctr <= '0;
    end else if (start_ev) begin
      active  <= 1'b1;
      idx     <= '0;
      mode_q  <= src_e'(src_mode);
      psel_q  <= prbs_sel;
      pinv_q  <= prbs15_inv;
      fsel_q  <= fixed_sel;
      ubyte_q <= user_byte;
      aal_q   <= aal1_en;
      csi_q   <= aal1_csi;
      if (aal1_en) begin
        seq_q   <= seq_ctr;
        seq_ctr <= seq_ctr + 3'd1;
      end
    end else if (xfer_ev) begin
      if (last_slot) active <= 1'b0;
      else           idx    <= idx + 1'b1;
    end
  end

  pyld_tstamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .tick(tick_100ns), .capture(start_ev), .ts_q(ts_q)
  );

  for (genvar g = 0; g < N_XPRBS; g++) begin : g_xprbs
    logic adv;
    assign adv = xfer_ev && !hdr_slot && (mode_q == SRC_XPRBS) && (psel_eff == 2'(g));
    pyld_lfsr #(.WIDTH(prbs_width(g)), .TAP(prbs_tap(g))) u_lfsr (
      .clk(clk), .rst_n(rst_n), .reseed(1'b0), .advance(adv), .byte_o(xbyte[g])
    );
  end

  logic cadv;
  assign cadv = xfer_ev && !hdr_slot && (mode_q == SRC_CPRBS);
  pyld_lfsr #(.WIDTH(9), .TAP(5)) u_cell_lfsr (
    .clk(clk), .rst_n(rst_n), .reseed(start_ev), .advance(cadv), .byte_o(cbyte)
  );

  always_comb begin
    pay_data = 8'h00;
    if (hdr_slot) begin
      pay_data = aal1_hdr(csi_q, seq_q);
    end else begin
      case (mode_q)
        SRC_TSTAMP:
          if (pidx < IDX_W'(TS_BYTES))
            pay_data = 8'(ts_q >> (8 * (TS_BYTES - 1 - int'(pidx))));
        SRC_XPRBS:
          pay_data = xbyte[psel_eff] ^ ((psel_eff == 2'd1 && pinv_q) ? 8'hFF : 8'h00);
        SRC_CPRBS: pay_data = cbyte;
        SRC_FIXED: pay_data = fixed_byte(fsel_q, ubyte_q, pidx[0]);
        SRC_RAMP:  pay_data = ubyte_q + 8'(pidx);
        default:   pay_data = 8'h00;
      endcase
    end
  end

  assign pay_valid = active;
  assign pay_last  = active && last_slot;

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> pay_valid && !pay_last);
  assert_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !pay_valid);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && !pay_ready) |=> pay_valid && $stable(pay_data) && $stable(pay_last));
  assert_hdr_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && hdr_slot) |-> (^pay_data) == 1'b0);
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && !done_ev) |=> $stable(mode_q) && $stable(ubyte_q) && $stable(psel_q));
endmodule

// File: tb/pyld_pattern_gen_test.sv
module pyld_pattern_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100ns = 1'b0, cell_start = 1'b0;
  logic [2:0] src_mode = '0;
  logic [1:0] prbs_sel = '0, fixed_sel = '0;
  logic       prbs15_inv = 1'b0, aal1_en = 1'b0, aal1_csi = 1'b0, pay_ready = 1'b0;
  logic [7:0] user_byte = '0;
  logic [7:0] pay_data;
  logic       pay_valid, pay_last;

  int checks = 0, errors = 0;
  int tb_ticks = 0;
  logic [22:0] m_x [3];
  logic [2:0]  m_seq = '0;
  logic [7:0]  exp_b [48];
  string       exp_r [48];

  always #4 clk = ~clk;

  pyld_pattern_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_100ns(tick_100ns), .cell_start(cell_start),
    .src_mode(src_mode), .prbs_sel(prbs_sel), .prbs15_inv(prbs15_inv),
    .fixed_sel(fixed_sel), .user_byte(user_byte), .aal1_en(aal1_en),
    .aal1_csi(aal1_csi), .pay_data(pay_data), .pay_valid(pay_valid),
    .pay_last(pay_last), .pay_ready(pay_ready)
  );

  always @(posedge clk) if (rst_n && tick_100ns) tb_ticks++;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // PRBS reference: bit list generation with explicit tap indices
  function automatic logic [7:0] m_prbs(inout logic [22:0] st, input int n, input int tap);
    logic [7:0] r;
    logic nb;
    for (int b = 0; b < 8; b++) begin
      r = {r[6:0], st[n-1]};
      nb = st[n-1] ^ st[tap-1];
      for (int k = n - 1; k > 0; k--) st[k] = st[k-1];
      st[0] = nb;
    end
    return r;
  endfunction

  // header reference: CRC by polynomial long division
  function automatic logic [7:0] m_hdr(input logic csi, input logic [2:0] cnt);
    logic [6:0] v;
    logic [6:0] top;
    v = {csi, cnt, 3'b000};
    for (int i = 6; i >= 3; i--)
      if (v[i]) v = v ^ (7'b1011 << (i - 3));
    top = {csi, cnt, v[2:0]};
    return {top, ^top};
  endfunction

  task automatic run_cell(input int mode, input int psel, input bit inv, input int fsel,
                          input logic [7:0] ub, input bit aal, input bit csi,
                          input bit disturb);
    int k;
    int n;
    int guard;
    bit held;
    logic [7:0] hdata;
    logic [22:0] cst;
    @(negedge clk);
    tick_100ns = 1'b0;
    src_mode = 3'(mode); prbs_sel = 2'(psel); prbs15_inv = inv; fixed_sel = 2'(fsel);
    user_byte = ub; aal1_en = aal; aal1_csi = csi; cell_start = 1'b1;
    k = 0;
    if (aal) begin
      exp_b[0] = m_hdr(csi, m_seq); exp_r[0] = "R10"; m_seq = m_seq + 3'd1; k = 1;
    end
    cst = '1;
    for (int i = k; i < 48; i++) begin
      int p;
      p = i - k;
      case (mode)
        0: begin exp_b[i] = (p < 4) ? 8'(tb_ticks >> (8 * (3 - p))) : 8'h00; exp_r[i] = "R4"; end
        1: begin
          exp_b[i] = m_prbs(m_x[psel], (psel == 0) ? 9 : (psel == 1) ? 15 : 23,
                            (psel == 0) ? 5 : (psel == 1) ? 14 : 18);
          if (psel == 1 && inv) begin exp_b[i] = ~exp_b[i]; exp_r[i] = "R6"; end
          else exp_r[i] = "R5";
        end
        2: begin exp_b[i] = m_prbs(cst, 9, 5); exp_r[i] = "R7"; end
        3: begin
          exp_b[i] = (fsel == 1) ? ((p % 2) ? 8'h55 : 8'hAA) :
                     (fsel == 2) ? ((p % 2) ? 8'h00 : 8'hFF) : ub;
          exp_r[i] = "R8";
        end
        default: begin exp_b[i] = ub + 8'(p); exp_r[i] = "R9"; end
      endcase
      if (disturb) exp_r[i] = {exp_r[i], "/R11"};
    end
    @(posedge clk);
    @(negedge clk);
    cell_start = 1'b0;
    if (disturb) begin  // R11: change every configuration input mid-cell
      src_mode = 3'($urandom % 5); prbs_sel = 2'($urandom); prbs15_inv = ~inv;
      fixed_sel = 2'($urandom); user_byte = 8'($urandom); aal1_en = ~aal; aal1_csi = ~csi;
    end
    n = 0; guard = 0; held = 1'b0; hdata = '0;
    while (n < 48 && guard < 1000) begin
      guard++;
      check(pay_valid === 1'b1, "R2 valid during cell", 32'(pay_valid), 1);
      if (held) check(pay_data === hdata, "R3 hold while stalled", pay_data, hdata);
      pay_ready = ($urandom % 4) != 0;
      tick_100ns = ($urandom % 3) == 0;
      if (disturb) cell_start = ($urandom % 8) == 0;  // R2: ignored while busy
      if (pay_ready) begin
        check(pay_data === exp_b[n], exp_r[n], pay_data, exp_b[n]);
        check(pay_last === (n == 47), "R2 last flag", 32'(pay_last), 32'(n == 47));
        n++; held = 1'b0;
      end else begin
        held = 1'b1; hdata = pay_data;
      end
      @(posedge clk);
      @(negedge clk);
    end
    cell_start = 1'b0; tick_100ns = 1'b0; pay_ready = 1'b0;
    check(pay_valid === 1'b0, "R2 idle after last byte", 32'(pay_valid), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 3; i++) m_x[i] = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pay_valid === 1'b0, "R1 valid in reset", 32'(pay_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pay_valid === 1'b0 && pay_last === 1'b0, "R1 idle after reset",
          {pay_valid, pay_last}, 0);
    // R1/R4: timestamp from zero, then after 700 ticks
    run_cell(0, 0, 0, 0, 8'h00, 0, 0, 0);
    @(negedge clk); tick_100ns = 1'b1;
    repeat (700) @(negedge clk);
    tick_100ns = 1'b0;
    run_cell(0, 0, 0, 0, 8'h00, 0, 0, 0);
    // R5: PRBS-9 twice, continuous state; PRBS-15, PRBS-23
    run_cell(1, 0, 0, 0, 8'h00, 0, 0, 0);
    run_cell(1, 0, 0, 0, 8'h00, 0, 0, 0);
    run_cell(1, 1, 0, 0, 8'h00, 0, 0, 0);
    run_cell(1, 2, 0, 0, 8'h00, 0, 0, 0);
    // R6: inverted PRBS-15; invert ignored on PRBS-9
    run_cell(1, 1, 1, 0, 8'h00, 0, 0, 0);
    run_cell(1, 0, 1, 0, 8'h00, 0, 0, 0);
    // R7: per-cell PRBS-9 repeats
    run_cell(2, 0, 0, 0, 8'h00, 0, 0, 0);
    run_cell(2, 0, 0, 0, 8'h00, 0, 0, 0);
    // R8: fixed patterns
    run_cell(3, 0, 0, 0, 8'h3C, 0, 0, 0);
    run_cell(3, 0, 0, 1, 8'h3C, 0, 0, 0);
    run_cell(3, 0, 0, 2, 8'h3C, 0, 0, 0);
    run_cell(3, 0, 0, 3, 8'h81, 0, 0, 0);
    // R9: ramp wrapping past 0xFF
    run_cell(4, 0, 0, 0, 8'hF0, 0, 0, 0);
    // R10: nine AAL-1 cells (count wraps), mixed sources, header skips PRBS
    for (int c = 0; c < 9; c++)
      run_cell(c % 5, c % 3, c[0], c % 4, 8'(c * 17), 1, c[1], 0);
    // R11 and R2: random cells with mid-cell disturbance
    for (int c = 0; c < 40; c++)
      run_cell($urandom % 5, $urandom % 3, 1'($urandom), $urandom % 4, 8'($urandom),
               1'($urandom), 1'($urandom), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule